// File: doc/BRIEF.md
# Bit-Field Packer with Start-Code Escaping

This block turns a sequence of variable-width bit fields into a byte-aligned stream and hands that stream out as 32-bit words. Each write request carries a value and a bit count. The block appends the low bits of the value, most significant bit first, to a 32-bit accumulator. It takes a byte off the top of the accumulator as soon as eight bits are held. The bytes are packed into words, big-endian, and each word leaves on a valid/ready port.

Escaping can be turned on for payloads that must never contain a start-code prefix. In that mode a 0x03 byte is placed in front of any byte from 0x00 to 0x03 that follows two zero bytes in a row. Three further commands operate on the stream. Align pads with zeros up to the next byte boundary. Flush pushes out a partial byte and a partial word. The last command switches escaping on or off. Two running counters report the bits accepted and the bits actually emitted, and the emitted count includes the inserted escape bytes.

Top module: `bitfield_packer`

## Requirements
- R1: A write of n bits (1 to 32) appends the n low bits of `cmd_data` directly after the bits already held, most significant bit first, and the bytes leave in stream order.
- R2: A write longer than the free space in the accumulator places its upper bits first and the remaining low bits after the accumulator has drained, so the bit order is preserved.
- R3: With escaping on, a 0x03 byte is emitted before a data byte of value 0x00, 0x01, 0x02 or 0x03 whenever the two preceding data bytes were zero since the last escape. The run of zeros then restarts from that data byte.
- R4: A data byte other than 0x00 ends a zero run. A data byte above 0x03 that follows two zero bytes gets no escape. Each inserted escape byte adds 8 to `bits_output`.
- R5: `cmd_op`=3 sets escaping to `cmd_data[0]`. Changing the setting clears the zero run, and writing the current setting again leaves the run intact.
- R6: `cmd_op`=1 (align) appends zero bits up to the next byte boundary and appends nothing when the stream is already aligned.
- R7: `cmd_op`=2 (flush) emits a held partial byte padded with low zeros, after escaping it if needed. It adds only the held bit count to `bits_output` and clears the zero run.
- R8: Output bytes fill a word from the most significant byte down. A flush releases a partly filled word with its unused low bytes at zero, and releases nothing when the word is empty.
- R9: `cmd_ready` is low while bytes wait to drain, a flush is in progress or split bits wait to be placed. While `out_valid` is high and `out_ready` is low, `out_word` holds its value and nothing drains.
- R10: A write with `cmd_len`=0 changes nothing, and a `cmd_len` above 32 is treated as 32.
- R11: `bits_written` adds the effective length of every write and the pad length of every align.
- R12: After reset, `out_valid` is low, `cmd_ready` is high, both counters are zero and escaping is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high together with `cmd_valid` |
| cmd_op | input | 2 | 0 write, 1 align, 2 flush, 3 escape enable |
| cmd_data | input | 32 | Write value, or the enable in bit 0 for op 3 |
| cmd_len | input | 6 | Write bit count (0 is ignored, above 32 is clamped) |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Packed word, first byte in bits 31:24 |
| bits_written | output | 32 | Bits accepted from writes and align padding |
| bits_output | output | 32 | Bits emitted, including escape bytes |

## Verification
The bench targets the corner cases of escaping. These include a data byte of 0x03 after two zeros, which a wrong design would pass through without an escape. They also include a byte above 0x03 after two zeros, which would gain a spurious escape, and a repeated enable write, which would lose the zero run if it cleared the count unconditionally. A 32-bit write landing on three held bits checks the split placement: a design that dropped or reordered the low remainder would give wrong later bytes. Flushes are run with an escaped tail byte, with an empty word and after a full word. A design that skipped the escape, counted 8 instead of the held bits, or released an empty word would show it in the words or the counters. A stalled output checks that `out_word` stays fixed and that `cmd_ready` falls.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_ALIGN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_ESCEN = 2'd3
  } bp_op_e;
endpackage

// File: rtl/bp_shifter.sv
module bp_shifter #(
  parameter int ACC_W = 32,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ACC_W-1:0] load_val_i,
  input  logic [LEN_W-1:0] load_len_i,
  input  logic             pop_i,
  input  logic             clear_i,
  output logic [LEN_W-1:0] held_o,
  output logic [7:0]       top_byte_o,
  output logic             rem_busy_o
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(ACC_W);
  localparam logic [LEN_W-1:0] BYTE = LEN_W'(8);

  logic [ACC_W-1:0] acc_q, acc_d, rv_q, rv_d, vmask;
  logic [LEN_W-1:0] held_q, held_d, rl_q, rl_d, free, over;
  logic             place_rem, en;

  assign free      = FULL - held_q;
  assign place_rem = (rl_q != '0) && (held_q < BYTE);
  assign en        = clear_i | pop_i | place_rem | (load_i && load_len_i != '0);
  assign vmask     = load_val_i & ({ACC_W{1'b1}} >> (FULL - load_len_i));
  assign over      = load_len_i - free;

  always_comb begin
    acc_d  = acc_q;
    held_d = held_q;
    rv_d   = rv_q;
    rl_d   = rl_q;
    if (clear_i) begin
      acc_d  = '0;
      held_d = '0;
    end else if (pop_i) begin
      acc_d  = acc_q << 8;
      held_d = held_q - BYTE;
    end else if (place_rem) begin
      acc_d  = acc_q | (rv_q << (free - rl_q));
      held_d = held_q + rl_q;
      rl_d   = '0;
      rv_d   = '0;
    end else if (load_i && load_len_i != '0) begin
      if (load_len_i <= free) begin
        acc_d  = acc_q | (vmask << (free - load_len_i));
        held_d = held_q + load_len_i;
      end else begin
        acc_d  = acc_q | (vmask >> over);
        held_d = FULL;
        rv_d   = vmask & ({ACC_W{1'b1}} >> (FULL - over));
        rl_d   = over;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      held_q <= '0;
      rv_q   <= '0;
      rl_q   <= '0;
    end else if (en) begin
      acc_q  <= acc_d;
      held_q <= held_d;
      rv_q   <= rv_d;
      rl_q   <= rl_d;
    end
  end

  assign held_o     = held_q;
  assign top_byte_o = acc_q[ACC_W-1 -: 8];
  assign rem_busy_o = (rl_q != '0);

  p_held_bound_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    held_q <= FULL);
  // R2: split remainder waits untouched until the accumulator drains below a byte
  p_rem_wait_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (rl_q != '0 && held_q >= BYTE) |=> (rl_q == $past(rl_q)));
endmodule

// File: rtl/bp_ep_filter.sv
module bp_ep_filter (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [7:0] byte_i,
  input  logic       tail_i,
  input  logic       set_i,
  input  logic       set_val_i,
  output logic       vld_o,
  output logic [7:0] byte_o,
  output logic       take_o
);
  logic [1:0] zeros_q, zeros_d;
  logic       en_q, en_d, esc, upd;

  assign esc    = req_i && en_q && (zeros_q >= 2'd2) && (byte_i <= 8'h03);
  assign vld_o  = req_i;
  assign byte_o = esc ? 8'h03 : byte_i;
  assign take_o = req_i && !esc;
  assign upd    = (set_i && set_val_i != en_q) || (req_i && en_q);

  always_comb begin
    en_d    = en_q;
    zeros_d = zeros_q;
    if (set_i && set_val_i != en_q) begin
      en_d    = set_val_i;
      zeros_d = '0;
    end else if (req_i && en_q) begin
      if (esc || tail_i || byte_i != 8'h00) zeros_d = '0;
      else if (zeros_q != 2'd2)             zeros_d = zeros_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      zeros_q <= '0;
    end else if (upd) begin
      en_q    <= en_d;
      zeros_q <= zeros_d;
    end
  end

  p_no_double_esc_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_i && !take_o) |=> !(req_i && !take_o));
  p_zero_sat_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    zeros_q <= 2'd2);
  p_same_en_keeps_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (set_i && set_val_i == en_q && !req_i) |=> (zeros_q == $past(zeros_q)));
endmodule

// File: rtl/bp_word_asm.sv
module bp_word_asm #(
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    b_vld_i,
  input  logic [7:0]              b_data_i,
  input  logic                    rel_i,
  input  logic                    out_ready_i,
  output logic                    out_valid_o,
  output logic [WORD_BYTES*8-1:0] out_word_o,
  output logic                    can_take_o
);
  localparam int WORD_W = WORD_BYTES * 8;
  localparam int IW     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam logic [IW-1:0] LAST = IW'(WORD_BYTES - 1);

  logic [WORD_W-1:0] word_q, word_d;
  logic [IW-1:0]     idx_q, idx_d, slot;
  logic              vld_q, vld_d;

  assign can_take_o = !vld_q || out_ready_i;
  assign slot       = LAST - idx_q;

  always_comb begin
    word_d = word_q;
    idx_d  = idx_q;
    vld_d  = vld_q && !out_ready_i;
    if (b_vld_i) begin
      word_d = ((idx_q == '0) ? '0 : word_q) | (WORD_W'(b_data_i) << {slot, 3'b000});
      idx_d  = idx_q + IW'(1);
      if (idx_q == LAST || rel_i) begin
        vld_d = 1'b1;
        idx_d = '0;
      end
    end else if (rel_i && idx_q != '0) begin
      vld_d = 1'b1;
      idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (b_vld_i || rel_i) begin
        word_q <= word_d;
        idx_q  <= idx_d;
      end
    end
  end

  assign out_valid_o = vld_q;
  assign out_word_o  = word_q;

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (vld_q && !out_ready_i) |=> (vld_q && $stable(word_q)));
  p_rel_empties_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    rel_i |=> (idx_q == '0));
endmodule

// File: rtl/bitfield_packer.sv
module bitfield_packer #(
  parameter int ACC_W      = 32,
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 32,
  parameter int LEN_W      = $clog2(ACC_W) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [1:0]              cmd_op,
  input  logic [ACC_W-1:0]        cmd_data,
  input  logic [LEN_W-1:0]        cmd_len,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_BYTES*8-1:0] out_word,
  output logic [CNT_W-1:0]        bits_written,
  output logic [CNT_W-1:0]        bits_output
);
  import bp_pkg::*;

  localparam logic [LEN_W-1:0] FULL = LEN_W'(ACC_W);
  localparam logic [LEN_W-1:0] BYTE = LEN_W'(8);

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  bp_op_e           op;
  logic [LEN_W-1:0] held, len_eff, pad, load_len;
  logic [2:0]       pad3;
  logic [7:0]       top_byte, f_byte;
  logic             rem_busy, can_take, flush_q, flush_d;
  logic             idle, fire, load, tail_mode, req, take, f_vld, flush_done;
  logic [CNT_W-1:0] wr_q, wr_d, outc_q, outc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign op        = bp_op_e'(cmd_op);
  assign idle      = (held < BYTE) && !rem_busy && !flush_q;
  assign cmd_ready = idle;
  assign fire      = cmd_valid && idle;
  assign len_eff   = (cmd_len > FULL) ? FULL : cmd_len;
  assign pad3      = 3'd0 - held[2:0];
  assign pad       = LEN_W'(pad3);
  assign load      = fire && (op == OP_WRITE || op == OP_ALIGN);
  assign load_len  = (op == OP_WRITE) ? len_eff : pad;

  assign tail_mode  = flush_q && !rem_busy && (held < BYTE);
  assign req        = can_take && ((held >= BYTE) || (tail_mode && held != '0));
  assign flush_done = can_take && tail_mode && ((held == '0) || take);

  bp_shifter #(.ACC_W(ACC_W), .LEN_W(LEN_W)) u_shifter (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i ((op == OP_WRITE) ? cmd_data : '0),
    .load_len_i (load_len),
    .pop_i      (take && !tail_mode),
    .clear_i    (take && tail_mode),
    .held_o     (held),
    .top_byte_o (top_byte),
    .rem_busy_o (rem_busy)
  );

  bp_ep_filter u_filter (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .byte_i    (top_byte),
    .tail_i    (tail_mode),
    .set_i     (fire && op == OP_ESCEN),
    .set_val_i (cmd_data[0]),
    .vld_o     (f_vld),
    .byte_o    (f_byte),
    .take_o    (take)
  );

  bp_word_asm #(.WORD_BYTES(WORD_BYTES)) u_words (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .b_vld_i     (f_vld),
    .b_data_i    (f_byte),
    .rel_i       (flush_done),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .out_word_o  (out_word),
    .can_take_o  (can_take)
  );

  always_comb begin
    flush_d = flush_q;
    if (fire && op == OP_FLUSH) flush_d = 1'b1;
    else if (flush_done)        flush_d = 1'b0;
    wr_d   = wr_q + (load ? CNT_W'(load_len) : '0);
    outc_d = outc_q;
    if (take && tail_mode) outc_d = outc_q + CNT_W'(held);
    else if (f_vld)        outc_d = outc_q + CNT_W'(8);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q <= 1'b0;
      wr_q    <= '0;
      outc_q  <= '0;
    end else begin
      flush_q <= flush_d;
      if (load)  wr_q   <= wr_d;
      if (f_vld) outc_q <= outc_d;
    end
  end

  assign bits_written = wr_q;
  assign bits_output  = outc_q;

  p_flush_busy_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (fire && op == OP_FLUSH) |=> !cmd_ready);
  p_out_mono_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (bits_output >= $past(bits_output) && bits_written >= $past(bits_written)));
  p_len0_noop_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (fire && op == OP_WRITE && cmd_len == '0) |=> (bits_written == $past(bits_written)));
endmodule

// File: tb/bitfield_packer_bench.sv
module bitfield_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready, out_valid, out_ready;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_data, out_word, bits_written, bits_output;
  logic [5:0]  cmd_len;
  logic [31:0] got[$];
  int          checks = 0, fails = 0;

  always #5 clk = ~clk;

  bitfield_packer u_bitfield_packer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_len(cmd_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .bits_written(bits_written), .bits_output(bits_output)
  );

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) got.push_back(out_word);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_data = '0; cmd_len = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    got.delete();
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [1:0] op, input logic [31:0] d, input logic [5:0] n);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_len = n;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d, input logic [5:0] n); send(2'd0, d, n); endtask
  task automatic settle(); repeat (20) @(posedge clk); #1; endtask

  task automatic chk_word(input int i, input logic [31:0] exp, input string req);
    chk(got.size() > i && got[i] == exp, req, (got.size() > i) ? got[i] : 32'hxxxxxxxx, exp);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 out_valid", {31'd0, out_valid}, 0);
    chk(cmd_ready == 1'b1, "R12 cmd_ready", {31'd0, cmd_ready}, 1);
    chk(bits_written == 0 && bits_output == 0, "R12 counters", bits_written | bits_output, 0);
  endtask

  task automatic t_pack();
    do_reset();
    wr(32'hA, 4); wr(32'hB, 4); wr(32'hFCDE, 12); wr(32'hF, 4); wr(32'h12, 8);
    wr(32'h34, 8); send(2'd2, 0, 0); settle();
    chk_word(0, 32'hABCDEF12, "R1 packed word");
    chk_word(1, 32'h34000000, "R8 partial word");
    chk(got.size() == 2, "R1 word count", got.size(), 2);
    chk(bits_written == 40, "R11 bits_written", bits_written, 40);
    chk(bits_output == 40, "R7 bits_output", bits_output, 40);
  endtask

  task automatic t_split();
    do_reset();
    wr(32'h5, 3); wr(32'hFFFF0000, 32); wr(32'h0, 5); send(2'd2, 0, 0); settle();
    chk_word(0, 32'hBFFFE000, "R2 split word");
    chk_word(1, 32'h00000000, "R2 split tail");
    chk(bits_output == 40, "R2 bits_output", bits_output, 40);
  endtask

  task automatic t_escape();
    do_reset();
    send(2'd3, 1, 0);
    wr(0, 8); wr(0, 8); wr(1, 8); wr(0, 8); wr(0, 8); wr(0, 8); wr(0, 8); wr(3, 8);
    wr(0, 8); wr(0, 8); wr(4, 8); send(2'd2, 0, 0); settle();
    chk_word(0, 32'h00000301, "R3 escape before 01");
    chk_word(1, 32'h00000300, "R3 escape before 00");
    chk_word(2, 32'h00030300, "R3 escape before 03");
    chk_word(3, 32'h00040000, "R4 no escape before 04");
    chk(bits_output == 112, "R4 escape bits counted", bits_output, 112);
    chk(bits_written == 88, "R11 bits_written", bits_written, 88);
  endtask

  task automatic t_enable();
    do_reset();
    send(2'd3, 1, 0); wr(0, 8); wr(0, 8); send(2'd3, 1, 0); wr(1, 8);
    wr(0, 8); wr(0, 8); send(2'd3, 0, 0); send(2'd3, 1, 0); wr(1, 8);
    send(2'd2, 0, 0); settle();
    chk_word(0, 32'h00000301, "R5 same enable keeps run");
    chk_word(1, 32'h00000100, "R5 toggle clears run");
  endtask

  task automatic t_align();
    do_reset();
    wr(32'h5, 3); send(2'd1, 0, 0); wr(32'hC3, 8); send(2'd1, 0, 0); settle();
    chk(bits_written == 16, "R6 align pad length", bits_written, 16);
    send(2'd2, 0, 0); settle();
    chk_word(0, 32'hA0C30000, "R6 aligned stream");
    chk(bits_output == 16, "R6 bits_output", bits_output, 16);
  endtask

  task automatic t_flush_esc();
    do_reset();
    send(2'd3, 1, 0); wr(0, 8); wr(0, 8); wr(0, 2); send(2'd2, 0, 0); settle();
    chk_word(0, 32'h00000300, "R7 escaped tail byte");
    chk(got.size() == 1, "R8 no empty release", got.size(), 1);
    chk(bits_output == 26, "R7 held bits counted", bits_output, 26);
    do_reset();
    send(2'd3, 1, 0); wr(0, 8); wr(0, 1); send(2'd2, 0, 0);
    wr(0, 8); wr(1, 8); send(2'd2, 0, 0); settle();
    chk_word(0, 32'h00000000, "R7 tail zero word");
    chk_word(1, 32'h00010000, "R7 flush clears zero run");
    chk(bits_output == 25, "R7 bits_output", bits_output, 25);
  endtask

  task automatic t_empty_flush();
    do_reset();
    wr(32'h11223344, 32); send(2'd2, 0, 0); send(2'd2, 0, 0); settle();
    chk_word(0, 32'h11223344, "R8 full word");
    chk(got.size() == 1, "R8 empty flush releases nothing", got.size(), 1);
  endtask

  task automatic t_stall();
    logic [31:0] w0;
    do_reset();
    out_ready = 1'b0;
    wr(32'h11223344, 32); wr(32'h5566, 16); settle();
    @(negedge clk);
    w0 = out_word;
    chk(out_valid == 1'b1, "R9 word waiting", {31'd0, out_valid}, 1);
    chk(cmd_ready == 1'b0, "R9 ready low while bytes pending", {31'd0, cmd_ready}, 0);
    repeat (5) @(negedge clk);
    chk(out_word == w0 && w0 == 32'h11223344, "R9 word held", out_word, 32'h11223344);
    @(posedge clk); #1; out_ready = 1'b1;
    send(2'd2, 0, 0); settle();
    chk_word(0, 32'h11223344, "R9 first after stall");
    chk_word(1, 32'h55660000, "R9 second after stall");
  endtask

  task automatic t_len();
    do_reset();
    wr(32'hFF, 0); wr(32'h12345678, 40); send(2'd2, 0, 0); settle();
    chk_word(0, 32'h12345678, "R10 clamp and zero length");
    chk(bits_written == 32, "R10 bits_written", bits_written, 32);
    chk(got.size() == 1, "R10 word count", got.size(), 1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_pack();
    t_split();
    t_escape();
    t_enable();
    t_align();
    t_flush_esc();
    t_empty_flush();
    t_stall();
    t_len();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule